// File: doc/BRIEF.md
# Byte Pointer Increment Sequencer

This block steps a 36-bit byte pointer on to the next byte. The word carries a 6-bit bit-position field in its top bits, a 6-bit byte-size field just below it, six bits that pass through untouched, and an 18-bit word address at the bottom. A start strobe loads the pointer. A chain of one-cycle steps then drives a 9-bit shift counter through a two-step serial adder. The block returns the advanced pointer and raises a one-cycle done strobe.

The counter first takes the one's complement of the position and then adds the size. The sign of that sum shows whether another byte still fits in the current word. If it does, the complemented counter is the new position. If it does not, the address is incremented, the counter is preset to a fixed constant and the size is added once more, which yields a position of 36 minus the size. A second entry, the write-back variant, only places the low six bits of the counter into the position field of the supplied pointer and leaves the counter as it is. A synchronous clear abandons any sequence in flight.

Top module: `bpi_incr`

## Requirements
- R1: Field layout: position in bits 35:30, size in bits 29:24, address in bits 17:0. For position P >= size S, the result has position P-S and every other bit of the input word. `done_o` is high in the cycle after the 10th rising edge that follows the edge which samples `start_i` with `alt_i` low.
- R2: For P < S, the result has address (A+1) mod 2^18, position (36-S) mod 64, and bits 29:18 unchanged. `done_o` is high in the cycle after the 19th rising edge that follows the sampling edge.
- R3: `done_o` is high for exactly one cycle per operation and only when no sequence is running.
- R4: A `start_i` that arrives while a sequence runs has no effect: neither the result nor the latency of the running operation changes.
- R5: A high `clr_i` on a rising edge ends any sequence without a done strobe. `ptr_o` keeps its value, and the block accepts a new start on the next cycle.
- R6: Write-back variant (`start_i` with `alt_i` high, while idle): on the next edge `ptr_o` becomes the supplied word with bits 35:30 replaced by the counter's low six bits. `done_o` goes high for one cycle and the counter keeps its value, so an immediate second write-back gives the same position.
- R7: The counter is zero after reset and after a completed pointer step, so a write-back at either point writes position 0.
- R8: Counter arithmetic is the complement-of-position plus size. After a clear that lands after the first XOR step, the counter's low six bits are ~P. After a clear that lands after the first carry step, they are (S-P-1) mod 64. The wrap preset is applied only to a zeroed counter.
- R9: After reset, `ptr_o` is zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Synchronous clear of the step chain |
| start_i | input | 1 | Start strobe, sampled only when idle |
| alt_i | input | 1 | With start: 1 selects write-back only, 0 the full step |
| ptr_i | input | 36 | Byte pointer to advance |
| ptr_o | output | 36 | Working pointer / result |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
The counter's intermediate values are the hardest part to observe from the ports. They live only inside the step chain, and a completed step always leaves the counter at zero. The bench reaches them by firing the clear at a chosen edge of a running step, which freezes the counter mid-calculation, and then issuing a write-back that copies its low six bits into the visible pointer. Apart from that, the bench runs a full sweep of all 4096 position and size pairs, including address wrap at all ones, with the expected pointer and latency computed arithmetically.

// File: rtl/bpi_pkg.sv
package bpi_pkg;
  localparam int WORD_W   = 36;
  localparam int FLD_W    = 6;
  localparam int CNT_W    = 9;
  localparam int ADDR_W   = 18;
  localparam int POS_LSB  = WORD_W - FLD_W;
  localparam int SIZE_LSB = POS_LSB - FLD_W;
  localparam int EXT_W    = CNT_W - FLD_W;
  // preset for the wrap pass; complementing preset+S leaves 36-S in the low field
  localparam logic [CNT_W-1:0] WRAP_PRESET = 9'o433;

  typedef enum logic [3:0] {
    ST_IDLE, ST_XPOS, ST_SEL_SZ, ST_DROP_POS, ST_XSZ, ST_GAP,
    ST_CARRY, ST_SUM_DONE, ST_TEST, ST_WRAP, ST_PRESET, ST_COMP, ST_WRITE
  } step_e;

  function automatic logic [CNT_W-1:0] addend_of(logic use_pos, logic use_size,
                                                 logic [FLD_W-1:0] pos,
                                                 logic [FLD_W-1:0] size);
    if (use_pos)  return {{EXT_W{1'b1}}, ~pos};
    if (use_size) return {{EXT_W{1'b0}}, size};
    return '0;
  endfunction

  function automatic logic [CNT_W-1:0] half_sum(logic [CNT_W-1:0] a, logic [CNT_W-1:0] b);
    return a ^ b;
  endfunction

  function automatic logic [CNT_W-1:0] carry_fold(logic [CNT_W-1:0] a, logic [CNT_W-1:0] b);
    return a + ((~a & b) << 1);
  endfunction
endpackage

// File: rtl/bpi_ctr.sv
module bpi_ctr
  import bpi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_pos,
  input  logic             use_size,
  input  logic [FLD_W-1:0] pos,
  input  logic [FLD_W-1:0] size,
  input  logic             op_clr,
  input  logic             op_xor,
  input  logic             op_carry,
  input  logic             op_comp,
  input  logic             op_preset,
  output logic [CNT_W-1:0] addend,
  output logic [CNT_W-1:0] cnt_q
);
  assign addend = addend_of(use_pos, use_size, pos, size);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (op_clr)    cnt_q <= '0;
    else if (op_xor)    cnt_q <= half_sum(cnt_q, addend);
    else if (op_carry)  cnt_q <= carry_fold(cnt_q, addend);
    else if (op_comp)   cnt_q <= ~cnt_q;
    else if (op_preset) cnt_q <= cnt_q | WRAP_PRESET;
  end
endmodule

// File: rtl/bpi_ptr.sv
module bpi_ptr
  import bpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] ptr_i,
  input  logic [FLD_W-1:0]  cnt_lo,
  input  logic              ld_ptr,
  input  logic              ld_alt,
  input  logic              addr_inc,
  input  logic              pos_write,
  output logic [WORD_W-1:0] ptr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          ptr_q <= '0;
    else if (ld_ptr)     ptr_q <= ptr_i;
    else if (ld_alt)     ptr_q <= {cnt_lo, ptr_i[POS_LSB-1:0]};
    else if (addr_inc)   ptr_q[ADDR_W-1:0] <= ptr_q[ADDR_W-1:0] + 1'b1;
    else if (pos_write)  ptr_q[WORD_W-1:POS_LSB] <= cnt_lo;
  end
endmodule

// File: rtl/bpi_seq.sv
module bpi_seq
  import bpi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic start_i,
  input  logic alt_i,
  input  logic sign_i,
  output logic ph_pos,
  output logic ph_size,
  output logic ld_ptr,
  output logic ld_alt,
  output logic cnt_clr,
  output logic cnt_xor,
  output logic cnt_carry,
  output logic cnt_comp,
  output logic cnt_preset,
  output logic addr_inc,
  output logic pos_write,
  output logic sign_test,
  output logic idle,
  output logic done_o
);
  step_e st, nx;
  logic  live;

  assign live       = !clr_i;
  assign idle       = (st == ST_IDLE);
  assign ld_ptr     = live && idle && start_i && !alt_i;
  assign ld_alt     = live && idle && start_i && alt_i;
  assign cnt_xor    = live && (st == ST_XPOS || st == ST_XSZ);
  assign cnt_carry  = live && (st == ST_CARRY);
  assign cnt_comp   = live && (st == ST_COMP);
  assign cnt_preset = live && (st == ST_PRESET);
  assign addr_inc   = live && (st == ST_WRAP);
  assign pos_write  = live && (st == ST_WRITE);
  assign sign_test  = live && (st == ST_TEST);
  assign cnt_clr    = ld_ptr || (live && (st == ST_WRAP || st == ST_WRITE));

  always_comb begin
    nx = st;
    case (st)
      ST_IDLE:     if (start_i && !alt_i) nx = ST_XPOS;
      ST_XPOS:     nx = ST_SEL_SZ;
      ST_SEL_SZ:   nx = ST_DROP_POS;
      ST_DROP_POS: nx = ST_XSZ;
      ST_XSZ:      nx = ST_GAP;
      ST_GAP:      nx = ST_CARRY;
      ST_CARRY:    nx = ST_SUM_DONE;
      ST_SUM_DONE: nx = ST_TEST;
      ST_TEST:     nx = sign_i ? ST_COMP : ST_WRAP;
      ST_WRAP:     nx = ST_PRESET;
      ST_PRESET:   nx = ST_SEL_SZ;
      ST_COMP:     nx = ST_WRITE;
      ST_WRITE:    nx = ST_IDLE;
      default:     nx = ST_IDLE;
    endcase
    if (clr_i) nx = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      ph_pos  <= 1'b0;
      ph_size <= 1'b0;
      done_o  <= 1'b0;
    end else if (clr_i) begin
      st      <= ST_IDLE;
      ph_pos  <= 1'b0;
      ph_size <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      st     <= nx;
      done_o <= ld_alt || pos_write;
      if (ld_ptr)                 ph_pos <= 1'b1;
      else if (st == ST_DROP_POS) ph_pos <= 1'b0;
      if (st == ST_SEL_SZ)        ph_size <= 1'b1;
      else if (st == ST_TEST)     ph_size <= 1'b0;
    end
  end
endmodule

// File: rtl/bpi_incr.sv
module bpi_incr
  import bpi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              start_i,
  input  logic              alt_i,
  input  logic [WORD_W-1:0] ptr_i,
  output logic [WORD_W-1:0] ptr_o,
  output logic              done_o
);
  logic             ph_pos, ph_size, ld_ptr, ld_alt;
  logic             cnt_clr, cnt_xor, cnt_carry, cnt_comp, cnt_preset;
  logic             addr_inc, pos_write, sign_test, idle_w;
  logic [CNT_W-1:0] addend_w, cnt_w;

  bpi_seq u_seq (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .start_i(start_i), .alt_i(alt_i),
    .sign_i(cnt_w[CNT_W-1]),
    .ph_pos(ph_pos), .ph_size(ph_size), .ld_ptr(ld_ptr), .ld_alt(ld_alt),
    .cnt_clr(cnt_clr), .cnt_xor(cnt_xor), .cnt_carry(cnt_carry),
    .cnt_comp(cnt_comp), .cnt_preset(cnt_preset), .addr_inc(addr_inc),
    .pos_write(pos_write), .sign_test(sign_test), .idle(idle_w), .done_o(done_o)
  );

  bpi_ctr u_ctr (
    .clk(clk), .rst_n(rst_n), .use_pos(ph_pos), .use_size(ph_size),
    .pos(ptr_o[WORD_W-1:POS_LSB]), .size(ptr_o[POS_LSB-1:SIZE_LSB]),
    .op_clr(cnt_clr), .op_xor(cnt_xor), .op_carry(cnt_carry),
    .op_comp(cnt_comp), .op_preset(cnt_preset),
    .addend(addend_w), .cnt_q(cnt_w)
  );

  bpi_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .ptr_i(ptr_i), .cnt_lo(cnt_w[FLD_W-1:0]),
    .ld_ptr(ld_ptr), .ld_alt(ld_alt), .addr_inc(addr_inc), .pos_write(pos_write),
    .ptr_q(ptr_o)
  );
endmodule

// File: rtl/bpi_incr_chk.sv
module bpi_incr_chk
  import bpi_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              clr_i,
  input logic              done_o,
  input logic [WORD_W-1:0] ptr_o,
  input logic              idle,
  input logic              addr_inc,
  input logic              cnt_preset,
  input logic              sign_test,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  addend
);
  AST_DONE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> idle); // R3
  AST_CLR_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (idle && !done_o)); // R5
  AST_CLR_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> $stable(ptr_o)); // R5
  AST_MID_FIELDS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(ptr_o[POS_LSB-1:ADDR_W])); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    addr_inc |=> ptr_o[ADDR_W-1:0] == $past(ptr_o[ADDR_W-1:0]) + 18'd1); // R2
  AST_PRESET_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_preset |-> cnt_q == '0); // R8
  AST_TEST_ON_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    sign_test |-> addend == {{EXT_W{1'b0}}, ptr_o[POS_LSB-1:SIZE_LSB]}); // R8
endmodule

bind bpi_incr bpi_incr_chk chk_i (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .done_o(done_o), .ptr_o(ptr_o),
  .idle(idle_w), .addr_inc(addr_inc), .cnt_preset(cnt_preset),
  .sign_test(sign_test), .cnt_q(cnt_w), .addend(addend_w)
);

// File: tb/bpi_incr_tb_top.sv
module bpi_incr_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr_i = 1'b0;
  logic        start_i = 1'b0;
  logic        alt_i = 1'b0;
  logic [35:0] ptr_i = '0;
  logic [35:0] ptr_o;
  logic        done_o;
  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpi_incr dut_i (.clk(clk), .rst_n(rst_n), .clr_i(clr_i), .start_i(start_i),
                  .alt_i(alt_i), .ptr_i(ptr_i), .ptr_o(ptr_o), .done_o(done_o));

  task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // called at a negedge; counts rising edges until done is seen
  task automatic wait_done(output int n);
    n = 0;
    while (!done_o && n < 40) begin
      @(posedge clk); n++; @(negedge clk);
    end
  endtask

  // drive a start at the negedge, returns edges after the sampling edge
  task automatic launch(input logic [35:0] p, input logic alt, output int n);
    ptr_i = p; alt_i = alt; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0; alt_i = 1'b0;
    wait_done(n);
  endtask

  function automatic logic [35:0] mk(int p, int s, int mid, logic [17:0] y);
    return {p[5:0], s[5:0], mid[5:0], y};
  endfunction

  function automatic logic [35:0] model(logic [35:0] w);
    logic [5:0] p, s;
    logic [17:0] y;
    p = w[35:30]; s = w[29:24]; y = w[17:0];
    if (p >= s) return {p - s, w[29:0]};
    return {6'd36 - s, w[29:18], y + 18'd1};
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    logic [35:0] w, wd;
    repeat (3) @(negedge clk);
    chk("R9 ptr after reset", ptr_o, '0);
    chk("R9 done after reset", {35'd0, done_o}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: write-back right after reset writes position 0
    wd = mk(50, 7, 9, 18'h1234);
    launch(wd, 1'b1, n);
    chk("R7 writeback after reset", ptr_o, {6'd0, wd[29:0]});
    chk("R6 writeback latency", n, 0);
    @(posedge clk); @(negedge clk);
    chk("R3 done single cycle", {35'd0, done_o}, '0);

    // exhaustive sweep of position and size (R1, R2)
    for (int p = 0; p < 64; p++) begin
      for (int s = 0; s < 64; s++) begin
        logic [17:0] y;
        y = 18'((p * 1031 + s * 77) & 'h3FFFF);
        if ((p + s) % 5 == 0) y = 18'h3FFFF;
        w = mk(p, s, p ^ s, y);
        launch(w, 1'b0, n);
        if (p >= s) begin
          chk("R1 result", ptr_o, model(w));
          chk("R1 latency", n, 10);
        end else begin
          chk("R2 result", ptr_o, model(w));
          chk("R2 latency", n, 19);
        end
        @(posedge clk); @(negedge clk);
        if (p == s) chk("R3 done drops", {35'd0, done_o}, '0);
      end
    end

    // R7: counter zero after a completed step
    wd = mk(33, 2, 5, 18'h00777);
    launch(wd, 1'b1, n);
    chk("R7 writeback after step", ptr_o, {6'd0, wd[29:0]});

    // R4: start during a run is ignored
    w = mk(20, 5, 3, 18'h2222);
    ptr_i = w; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    @(posedge clk); @(negedge clk);
    ptr_i = mk(1, 60, 0, 18'h1); start_i = 1'b1; alt_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0; alt_i = 1'b0;
    wait_done(n);
    chk("R4 busy start ignored result", ptr_o, model(w));
    chk("R4 busy start ignored latency", n + 2, 10);

    // R5/R8: clear after the first XOR step
    w = mk(13, 40, 21, 18'h0ABCD);
    ptr_i = w; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    @(posedge clk); @(negedge clk);
    clr_i = 1'b1;
    @(posedge clk); @(negedge clk);
    clr_i = 1'b0;
    chk("R5 no done on clear", {35'd0, done_o}, '0);
    repeat (25) @(negedge clk);
    chk("R5 ptr held after clear", ptr_o, w);
    chk("R5 still no done", {35'd0, done_o}, '0);
    wd = mk(0, 11, 2, 18'h3F000);
    launch(wd, 1'b1, n);
    chk("R8 counter after xor", ptr_o, {6'(~6'd13), wd[29:0]});
    chk("R5 start accepted after clear", n, 0);
    wd = mk(0, 12, 4, 18'h00042);
    launch(wd, 1'b1, n);
    chk("R6 counter kept by writeback", ptr_o, {6'(~6'd13), wd[29:0]});

    // R8: clear after the first carry step (P=5, S=9 -> 3)
    w = mk(5, 9, 1, 18'h00100);
    ptr_i = w; start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    repeat (6) begin @(posedge clk); @(negedge clk); end
    clr_i = 1'b1;
    @(posedge clk); @(negedge clk);
    clr_i = 1'b0;
    wd = mk(63, 1, 1, 18'h0);
    launch(wd, 1'b1, n);
    chk("R8 counter after carry", ptr_o, {6'd3, wd[29:0]});

    // R1: step after an aborted run starts from a clean counter
    w = mk(36, 36, 0, 18'h3FFFF);
    launch(w, 1'b0, n);
    chk("R1 step after abort", ptr_o, model(w));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule